// File: doc/BRIEF.md
# Three-in-a-Row Bit Detector

This block watches a single serial bit and raises its output while the bit currently on the input agrees with the value it had at each of the two most recent rising clock edges. The output is a Mealy output: it is a combinational function of the stored history and the live input. It can therefore rise or fall in the middle of a clock period when the input moves, without waiting for an edge.

The history is held as a five-state symbolic machine in a three-bit register. The states are: nothing sampled, one sample of 0, one sample of 1, two samples of 0, and two samples of 1. Only the two-sample states can drive the output high. Reset is active-high. It clears the history at the next clock edge, and it also gates the output directly, so the output is low from the moment reset rises and does not wait for an edge.

Top module: `repeat_detector`

## Requirements
- R1: While `rst` is 1, `y` is 0 for every value of `a`, and it drops to 0 in the same cycle that `rst` rises, before any clock edge.
- R2: After `rst` falls, `y` stays 0 until at least two rising edges with `rst` low have sampled `a`; samples taken before or during reset never count.
- R3: With `rst` low, `y` is 1 exactly when the present `a` equals the `a` sampled at each of the last two rising edges (both since reset), for runs of 0 and runs of 1 alike.
- R4: `y` follows a change of `a` within the clock period, with no clock edge needed; toggling `a` mid-cycle away from a two-sample run drops `y`, and toggling it back raises `y` again.
- R5: An edge that samples a value different from the one before it breaks the run: `y` cannot be 1 again until two further edges have sampled the new value.
- R6: Asserting `rst` in the middle of a run discards the stored history, so after release the run must be rebuilt from two fresh samples.
- R7: The state register holds only the five encodings 0 (empty), 1 (one 0), 2 (one 1), 3 (two 0s) and 4 (two 1s).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock that samples `a` |
| rst | input | 1 | Active-high reset; clears history at the edge and forces `y` low at once |
| a | input | 1 | Serial data bit under observation |
| y | output | 1 | High while the live `a` matches the two previous samples |

## Verification
The assertions assume that `a` and `rst` are steady across each rising edge. This ensures that the sampled value is the one the state register captured. They also assume that reset has been held for at least two edges before the first release, so that the history properties never reach back to times with no defined values. The bench drives `a` and `rst` only after falling edges or at mid-period points, never close to a rising edge. It begins with several reset cycles. Mid-cycle toggles of `a` and a mid-cycle rise of `rst` exercise the combinational paths, and they stay well clear of the sampling edge.

// File: rtl/rvd_pkg.sv
package rvd_pkg;

  localparam int NUM_STATES = 5;
  localparam int STATE_W    = $clog2(NUM_STATES);

  // Encoding is checked by the bound checker (R7).
  typedef enum logic [STATE_W-1:0] {
    ST_EMPTY = 3'd0,
    ST_SEEN0 = 3'd1,
    ST_SEEN1 = 3'd2,
    ST_PAIR0 = 3'd3,
    ST_PAIR1 = 3'd4
  } rvd_state_e;

endpackage

// File: rtl/rvd_next_state.sv
module rvd_next_state
  import rvd_pkg::*;
(
  input  rvd_state_e cur,
  input  logic       bit_in,
  output rvd_state_e nxt
);

  always_comb begin
    unique case (cur)
      ST_EMPTY: nxt = bit_in ? ST_SEEN1 : ST_SEEN0;
      ST_SEEN0: nxt = bit_in ? ST_SEEN1 : ST_PAIR0;
      ST_SEEN1: nxt = bit_in ? ST_PAIR1 : ST_SEEN0;
      ST_PAIR0: nxt = bit_in ? ST_SEEN1 : ST_PAIR0;
      ST_PAIR1: nxt = bit_in ? ST_PAIR1 : ST_SEEN0;
      default:  nxt = ST_EMPTY;
    endcase
  end

endmodule

// File: rtl/rvd_state_reg.sv
module rvd_state_reg
  import rvd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  rvd_state_e nxt,
  output rvd_state_e cur
);

  always_ff @(posedge clk) begin
    if (rst) cur <= ST_EMPTY;
    else     cur <= nxt;
  end

endmodule

// File: rtl/rvd_output.sv
module rvd_output
  import rvd_pkg::*;
(
  input  logic       rst,
  input  rvd_state_e cur,
  input  logic       bit_in,
  output logic       match
);

  logic pair_hit;

  always_comb begin
    unique case (cur)
      ST_PAIR0: pair_hit = ~bit_in;
      ST_PAIR1: pair_hit = bit_in;
      default:  pair_hit = 1'b0;
    endcase
    // reset gates the output directly so it falls before any edge
    match = pair_hit & ~rst;
  end

endmodule

// File: rtl/repeat_detector.sv
module repeat_detector
  import rvd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a,
  output logic y
);

  rvd_state_e state_q;
  rvd_state_e state_d;

  rvd_next_state u_next (
    .cur    (state_q),
    .bit_in (a),
    .nxt    (state_d)
  );

  rvd_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .nxt (state_d),
    .cur (state_q)
  );

  rvd_output u_out (
    .rst    (rst),
    .cur    (state_q),
    .bit_in (a),
    .match  (y)
  );

endmodule

// File: rtl/repeat_detector_chk.sv
module repeat_detector_chk (
  input logic       clk,
  input logic       rst,
  input logic       a,
  input logic       y,
  input logic [2:0] st
);

  // R1: reset holds the output low
  a_r1_reset_low: assert property (@(posedge clk) rst |-> !y);

  // R2: no output in the first cycle after release
  a_r2_one_sample: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !y);

  // R2: nor in the second
  a_r2_two_samples: assert property (@(posedge clk) disable iff (rst)
    $past(rst, 2) |-> !y);

  // R3: a high output implies both previous samples agree with a
  a_r3_match_implied: assert property (@(posedge clk) disable iff (rst)
    y |-> (a == $past(a) && a == $past(a, 2)));

  // R3: agreement with two post-reset samples implies a high output
  a_r3_match_seen: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && a == $past(a) && a == $past(a, 2)) |-> y);

  // R7: only the five legal encodings appear
  a_r7_state_legal: assert property (@(posedge clk) disable iff (rst)
    st <= 3'd4);

endmodule

bind repeat_detector repeat_detector_chk u_chk (
  .clk (clk),
  .rst (rst),
  .a   (a),
  .y   (y),
  .st  (state_q)
);

// File: tb/tb_repeat_detector.sv
module tb_repeat_detector;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a   = 1'b0;
  logic y;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic hist[$];  // newest sample at index 0

  repeat_detector dut (.clk(clk), .rst(rst), .a(a), .y(y));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic expect_y();
    if (rst) return 1'b0;
    if (hist.size() < 2) return 1'b0;
    return (a == hist[0]) && (a == hist[1]);
  endfunction

  task automatic check(input string tag);
    logic e;
    e = expect_y();
    checks++;
    if (y !== e) begin
      errors++;
      $display("FAIL %s: y=%b expected %b (a=%b rst=%b t=%0t)", tag, y, e, a, rst, $time);
    end
  endtask

  // one clock cycle: drive after the falling edge, check, optional mid toggle,
  // then check again just after the rising edge
  task automatic cyc(input logic av, input logic rv, input bit flip, input string tag);
    @(negedge clk);
    a = av;
    rst = rv;
    #1 check(tag);
    if (flip) begin
      a = ~a;
      #1 check({tag, " mid-toggle"});
      a = ~a;
      #1 check({tag, " toggle-back"});
    end
    @(posedge clk);
    if (rst) hist.delete();
    else begin
      hist.push_front(a);
      if (hist.size() > 2) void'(hist.pop_back());
    end
    #1 check({tag, " post-edge"});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    // R1: reset held, a wiggled, y stays 0
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1, "R1 reset hold");
    cyc(1'b0, 1'b1, 1'b1, "R1 reset hold a=0");

    // R2: samples of 1 after release; no output before two edges
    cyc(1'b1, 1'b0, 1'b1, "R2 first sample");
    cyc(1'b1, 1'b0, 1'b1, "R2 second sample");
    // R3: run of ones, y high
    cyc(1'b1, 1'b0, 1'b0, "R3 run of ones");
    // R4: mid-cycle toggle drops and restores y
    cyc(1'b1, 1'b0, 1'b1, "R4 mealy toggle");
    // R5: break the run with a 0
    cyc(1'b0, 1'b0, 1'b0, "R5 break");
    cyc(1'b1, 1'b0, 1'b1, "R5 new value one");
    cyc(1'b1, 1'b0, 1'b0, "R5 one sample of 1");
    cyc(1'b1, 1'b0, 1'b1, "R5 rebuilt run");
    // R3: run of zeros
    cyc(1'b0, 1'b0, 1'b0, "R3 zeros a");
    cyc(1'b0, 1'b0, 1'b0, "R3 zeros b");
    cyc(1'b0, 1'b0, 1'b1, "R3 zeros run");
    cyc(1'b0, 1'b0, 1'b0, "R3 zeros hold");
    // R5: alternating pattern never matches
    for (int i = 0; i < 6; i++) cyc(i[0], 1'b0, 1'b1, "R5 alternate");

    // R1: reset rising mid-cycle in an active run drops y immediately
    cyc(1'b1, 1'b0, 1'b0, "R6 build a");
    cyc(1'b1, 1'b0, 1'b0, "R6 build b");
    @(negedge clk);
    #1 check("R1 run active before reset");
    rst = 1'b1;
    #1 check("R1 immediate drop");
    @(posedge clk);
    hist.delete();
    #1 check("R1 post-edge in reset");
    // R6: history discarded after release
    cyc(1'b1, 1'b0, 1'b1, "R6 after release 1");
    cyc(1'b1, 1'b0, 1'b1, "R6 after release 2");
    cyc(1'b1, 1'b0, 1'b1, "R6 rebuilt");

    // mixed pattern sweep
    for (int i = 0; i < 40; i++)
      cyc(((i * 7) % 5) > 1, (i == 25), i[1], "R3 sweep");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule